// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the state update a core needs when it accepts an exception or an interrupt. The core has three privilege levels: user, supervisor and machine. In the cycle where the pipeline presents a trap, the controller picks the handling level and loads that level's trap state. It also returns the handler address and the new privilege. In the same cycle it pulses a strobe that drops any outstanding load reservation.

The choice of level comes from two delegation masks held in the block, one for synchronous exceptions and one for interrupts. A trap raised in user or supervisor mode goes to the supervisor level when its cause bit is set in the matching mask. Every other trap goes to the machine level. The cause code the pipeline reports for an environment call is the user one, and the block rewrites it to the code of the privilege the call came from. Each level has a handler base whose two low bits select direct or vectored entry. With vectored entry an interrupt lands at four times its cause past the base. The CSR unit outside the block loads the vectors, the masks and the two interrupt-enable bits through a narrow, already-decoded write port.

Top module: `trap_entry_ctrl`

## Requirements
- R1: Privilege encoding is U=0, S=1, M=3. With `trap_valid` high, `nxt_priv` is S when `cur_priv` is not M and bit `code` of the delegation mask is set, and M otherwise. Here `code` is the cause after the R9 rewrite, and the mask is the interrupt mask when `trap_async` is 1 and the exception mask when it is 0. With `trap_valid` low, `nxt_priv` equals `cur_priv`.
- R2: A trap routed to S loads the S-level state at the next clock edge: `s_pie` takes the old `s_ie`, `s_pp` takes `cur_priv[0]`, and `s_ie` becomes 0. All M-level state stays unchanged.
- R3: A trap routed to M loads the M-level state at the next clock edge: `m_pie` takes the old `m_ie`, `m_pp` takes `cur_priv`, and `m_ie` becomes 0. All S-level state stays unchanged.
- R4: The selected level's cause register becomes the cause code in bits [CAUSE_W-1:0], with bit XLEN-1 equal to `trap_async` and every other bit zero.
- R5: The selected level's exception-PC register captures `trap_pc`.
- R6: The selected level's trap-value register captures `trap_addr` for synchronous causes 0 to 7, 12, 13 and 15. For every other cause, and for all interrupts, it captures zero.
- R7: `nxt_pc` is the selected level's vector with bits [1:0] cleared, for every synchronous trap and for every trap whose vector bits [1:0] are not 01.
- R8: When the vector bits [1:0] equal 01 and the trap is an interrupt, `nxt_pc` is the cleared vector plus 4 times the cause code.
- R9: A synchronous trap with input cause 8 is recorded and routed as cause 8 from U, 9 from S and 11 from M. Interrupt cause 8 is not rewritten.
- R10: `resv_clr` is high in exactly the cycles where `trap_valid` is high, including traps that keep the privilege unchanged.
- R11: After reset every status bit, cause, exception-PC, trap-value, vector and delegation register is zero.
- R12: Write-port selects are 0 machine vector, 1 supervisor vector, 2 exception delegation, 3 interrupt delegation and 4 enables (bit 1 `m_ie`, bit 0 `s_ie`). A write presented in the same cycle as a trap is dropped.
- R13: With neither a trap nor a write, all held state keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for vectors, masks and enables |
| cfg_sel | input | 3 | Decoded target of the write (see R12) |
| cfg_data | input | XLEN | Write data |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_async | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_code | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| nxt_pc | output | XLEN | Handler address for the current trap |
| nxt_priv | output | 2 | Privilege after the trap |
| resv_clr | output | 1 | Load-reservation clear strobe |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous interrupt enable |
| m_pp | output | 2 | Machine previous privilege |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous interrupt enable |
| s_pp | output | 1 | Supervisor previous privilege |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |

## Verification
The hard case is where the environment-call rewrite, delegation and vectoring combine. The rewritten cause, not the raw one, must index the mask. Then an interrupt with the same raw code must bypass both the rewrite and the trap-value capture. To reach it, the stimulus sweeps every cause code against both trap kinds and all three privileges. It does this under two mask and vector setups chosen so that causes 8, 9 and 11 land on different levels and each level sees both direct and vectored entry. A write issued in the same cycle as a trap, followed by a second trap, shows at the ports that the write was dropped.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUPV = 2'd1,
      LVL_MACH = 2'd3
   } lvl_e;

   typedef enum logic [2:0] {
      CSEL_MVEC    = 3'd0,
      CSEL_SVEC    = 3'd1,
      CSEL_DLG_EXC = 3'd2,
      CSEL_DLG_IRQ = 3'd3,
      CSEL_ENABLES = 3'd4
   } cfg_sel_e;

   localparam int unsigned ENVCALL_FROM_U = 8;
   localparam int unsigned ENVCALL_FROM_S = 9;
   localparam int unsigned ENVCALL_FROM_M = 11;

   // synchronous causes that report an address in the trap-value register
   function automatic logic code_reports_addr(input int unsigned code);
      return (code <= 7) || (code == 12) || (code == 13) || (code == 15);
   endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_we,
   input  logic               irq_we,
   input  logic [XLEN-1:0]    wdata,
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] code_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    addr_i,
   output logic [CAUSE_W-1:0] code_o,
   output logic               to_supv_o,
   output logic [XLEN-1:0]    tval_o
);

   logic [XLEN-1:0] exc_mask_q;
   logic [XLEN-1:0] irq_mask_q;
   logic [XLEN-1:0] mask_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_mask_q <= '0;
         irq_mask_q <= '0;
      end else begin
         if (exc_we) exc_mask_q <= wdata;
         if (irq_we) irq_mask_q <= wdata;
      end
   end

   // environment-call code follows the level the call came from
   always_comb begin
      code_o = code_i;
      if (!async_i && (32'(code_i) == ENVCALL_FROM_U)) begin
         unique case (priv_i)
            LVL_SUPV: code_o = CAUSE_W'(ENVCALL_FROM_S);
            LVL_MACH: code_o = CAUSE_W'(ENVCALL_FROM_M);
            default:  code_o = CAUSE_W'(ENVCALL_FROM_U);
         endcase
      end
   end

   assign mask_sel  = async_i ? irq_mask_q : exc_mask_q;
   assign to_supv_o = (priv_i != LVL_MACH) && mask_sel[code_o];
   assign tval_o    = (!async_i && code_reports_addr(32'(code_o))) ? addr_i : '0;

endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter bit          VEC_EN  = 1'b1
) (
   input  logic [XLEN-1:0]    tvec_i,
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] code_i,
   output logic [XLEN-1:0]    pc_o
);

   localparam logic [1:0] MODE_VECTORED = 2'b01;

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign base = {tvec_i[XLEN-1:2], 2'b00};

   generate
      if (VEC_EN) begin : g_vectored
         assign offset = (async_i && (tvec_i[1:0] == MODE_VECTORED)) ?
                         XLEN'({code_i, 2'b00}) : '0;
      end else begin : g_direct
         assign offset = '0;
      end
   endgenerate

   assign pc_o = base + offset;

endmodule

// File: rtl/trap_level_bank.sv
module trap_level_bank #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter int unsigned PP_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tvec_we,
   input  logic               ie_we,
   input  logic               ie_wd,
   input  logic [XLEN-1:0]    wdata,
   input  logic               take_i,
   input  logic               async_i,
   input  logic [CAUSE_W-1:0] code_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    tval_i,
   input  logic [1:0]         priv_i,
   output logic [XLEN-1:0]    tvec_o,
   output logic               ie_o,
   output logic               pie_o,
   output logic [1:0]         pp_o,
   output logic [XLEN-1:0]    cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic [XLEN-1:0]    tval_o
);

   logic [PP_W-1:0] pp_q;
   logic [XLEN-1:0] cause_d;

   always_comb begin
      cause_d              = '0;
      cause_d[CAUSE_W-1:0] = code_i;
      cause_d[XLEN-1]      = async_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tvec_o  <= '0;
         ie_o    <= 1'b0;
         pie_o   <= 1'b0;
         pp_q    <= '0;
         cause_o <= '0;
         epc_o   <= '0;
         tval_o  <= '0;
      end else if (take_i) begin
         pie_o   <= ie_o;
         ie_o    <= 1'b0;
         pp_q    <= priv_i[PP_W-1:0];
         cause_o <= cause_d;
         epc_o   <= pc_i;
         tval_o  <= tval_i;
      end else begin
         if (tvec_we) tvec_o <= wdata;
         if (ie_we)   ie_o   <= ie_wd;
      end
   end

   generate
      if (PP_W >= 2) begin : g_pp_full
         assign pp_o = pp_q[1:0];
      end else begin : g_pp_narrow
         assign pp_o = {1'b0, pp_q[0]};
      end
   endgenerate

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter bit          VEC_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [XLEN-1:0]    cfg_data,
   input  logic               trap_valid,
   input  logic               trap_async,
   input  logic [CAUSE_W-1:0] trap_code,
   input  logic [XLEN-1:0]    trap_addr,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic [1:0]         cur_priv,
   output logic [XLEN-1:0]    nxt_pc,
   output logic [1:0]         nxt_priv,
   output logic               resv_clr,
   output logic               m_ie,
   output logic               m_pie,
   output logic [1:0]         m_pp,
   output logic [XLEN-1:0]    m_cause,
   output logic [XLEN-1:0]    m_epc,
   output logic [XLEN-1:0]    m_tval,
   output logic               s_ie,
   output logic               s_pie,
   output logic               s_pp,
   output logic [XLEN-1:0]    s_cause,
   output logic [XLEN-1:0]    s_epc,
   output logic [XLEN-1:0]    s_tval
);

   localparam int unsigned N_LVL   = 2;   // index 0: supervisor, 1: machine
   localparam int unsigned N_CODES = 1 << CAUSE_W;

   initial begin
      assert (N_CODES <= XLEN) else $error("cause space exceeds delegation mask width");
      assert (XLEN >= 8)       else $error("XLEN too small");
   end

   logic                 wr_ok;
   logic [CAUSE_W-1:0]   eff_code;
   logic                 to_supv;
   logic [XLEN-1:0]      tval_val;
   logic [XLEN-1:0]      sel_tvec;
   logic [XLEN-1:0]      vec_pc;

   logic [XLEN-1:0] l_tvec  [N_LVL];
   logic            l_ie    [N_LVL];
   logic            l_pie   [N_LVL];
   logic [1:0]      l_pp    [N_LVL];
   logic [XLEN-1:0] l_cause [N_LVL];
   logic [XLEN-1:0] l_epc   [N_LVL];
   logic [XLEN-1:0] l_tval  [N_LVL];

   assign wr_ok = cfg_we && !trap_valid;

   trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .exc_we    (wr_ok && (cfg_sel == CSEL_DLG_EXC)),
      .irq_we    (wr_ok && (cfg_sel == CSEL_DLG_IRQ)),
      .wdata     (cfg_data),
      .async_i   (trap_async),
      .code_i    (trap_code),
      .priv_i    (cur_priv),
      .addr_i    (trap_addr),
      .code_o    (eff_code),
      .to_supv_o (to_supv),
      .tval_o    (tval_val)
   );

   generate
      for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
         localparam bit IS_M = (lv == 1);
         localparam logic [2:0] VEC_SEL = IS_M ? 3'(CSEL_MVEC) : 3'(CSEL_SVEC);
         trap_level_bank #(
            .XLEN    (XLEN),
            .CAUSE_W (CAUSE_W),
            .PP_W    (IS_M ? 2 : 1)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .tvec_we (wr_ok && (cfg_sel == VEC_SEL)),
            .ie_we   (wr_ok && (cfg_sel == CSEL_ENABLES)),
            .ie_wd   (cfg_data[lv]),
            .wdata   (cfg_data),
            .take_i  (trap_valid && (IS_M ? !to_supv : to_supv)),
            .async_i (trap_async),
            .code_i  (eff_code),
            .pc_i    (trap_pc),
            .tval_i  (tval_val),
            .priv_i  (cur_priv),
            .tvec_o  (l_tvec[lv]),
            .ie_o    (l_ie[lv]),
            .pie_o   (l_pie[lv]),
            .pp_o    (l_pp[lv]),
            .cause_o (l_cause[lv]),
            .epc_o   (l_epc[lv]),
            .tval_o  (l_tval[lv])
         );
      end
   endgenerate

   assign sel_tvec = to_supv ? l_tvec[0] : l_tvec[1];

   trap_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN)) u_vec (
      .tvec_i  (sel_tvec),
      .async_i (trap_async),
      .code_i  (eff_code),
      .pc_o    (vec_pc)
   );

   assign nxt_pc   = vec_pc;
   assign nxt_priv = !trap_valid ? cur_priv : (to_supv ? LVL_SUPV : LVL_MACH);
   assign resv_clr = trap_valid;

   assign m_ie    = l_ie[1];
   assign m_pie   = l_pie[1];
   assign m_pp    = l_pp[1];
   assign m_cause = l_cause[1];
   assign m_epc   = l_epc[1];
   assign m_tval  = l_tval[1];
   assign s_ie    = l_ie[0];
   assign s_pie   = l_pie[0];
   assign s_pp    = l_pp[0][0];
   assign s_cause = l_cause[0];
   assign s_epc   = l_epc[0];
   assign s_tval  = l_tval[0];

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            trap_valid,
   input logic            trap_async,
   input logic [XLEN-1:0] trap_pc,
   input logic [1:0]      cur_priv,
   input logic [XLEN-1:0] nxt_pc,
   input logic [1:0]      nxt_priv,
   input logic            resv_clr,
   input logic            m_ie,
   input logic            m_pie,
   input logic [1:0]      m_pp,
   input logic [XLEN-1:0] m_cause,
   input logic [XLEN-1:0] m_epc,
   input logic [XLEN-1:0] m_tval,
   input logic            s_ie,
   input logic            s_pie,
   input logic            s_pp,
   input logic [XLEN-1:0] s_cause,
   input logic [XLEN-1:0] s_epc,
   input logic [XLEN-1:0] s_tval
);

   AST_M_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && cur_priv == 2'd3) |-> nxt_priv == 2'd3);  // R1

   AST_S_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd1) |=> (!s_ie && s_pie == $past(s_ie) && s_pp == $past(cur_priv[0])));  // R2

   AST_S_ENTRY_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd1) |=> ($stable(m_cause) && $stable(m_epc) && $stable(m_ie)));  // R2

   AST_M_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd3) |=> (!m_ie && m_pie == $past(m_ie) && m_pp == $past(cur_priv)));  // R3

   AST_M_ENTRY_KEEPS_S: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd3) |=> ($stable(s_cause) && $stable(s_epc) && $stable(s_ie)));  // R3

   AST_CAUSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd3) |=> m_cause[XLEN-1] == $past(trap_async));  // R4

   AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && nxt_priv == 2'd1) |=> s_epc == $past(trap_pc));  // R5

   AST_IRQ_TVAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_async && nxt_priv == 2'd3) |=> m_tval == '0);  // R6

   AST_SYNC_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_async) |-> nxt_pc[1:0] == 2'b00);  // R7

   AST_RESV_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      resv_clr |-> (nxt_priv == 2'd1 || nxt_priv == 2'd3));  // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_valid && !cfg_we) |=> ($stable(m_cause) && $stable(s_cause) && $stable(m_tval)
                                    && $stable(s_tval) && $stable(m_ie) && $stable(s_ie)
                                    && $stable(m_pie) && $stable(s_pie)));  // R13

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .trap_valid(trap_valid),
   .trap_async(trap_async), .trap_pc(trap_pc), .cur_priv(cur_priv),
   .nxt_pc(nxt_pc), .nxt_priv(nxt_priv), .resv_clr(resv_clr),
   .m_ie(m_ie), .m_pie(m_pie), .m_pp(m_pp), .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval),
   .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval)
);

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_data = '0;
   logic        trap_valid = 1'b0;
   logic        trap_async = 1'b0;
   logic [4:0]  trap_code = '0;
   logic [31:0] trap_addr = '0;
   logic [31:0] trap_pc = '0;
   logic [1:0]  cur_priv = '0;
   logic [31:0] nxt_pc;
   logic [1:0]  nxt_priv;
   logic        resv_clr;
   logic        m_ie, m_pie, s_ie, s_pie, s_pp;
   logic [1:0]  m_pp;
   logic [31:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;

   int n_chk = 0;
   int n_err = 0;

   // bench copies of the configuration, kept from what it writes
   logic [31:0] mvec_m, svec_m, dexc_m, dirq_m;

   always #(CLK_P/2) clk = ~clk;

   trap_entry_ctrl u_trap_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .trap_valid(trap_valid), .trap_async(trap_async), .trap_code(trap_code),
      .trap_addr(trap_addr), .trap_pc(trap_pc), .cur_priv(cur_priv),
      .nxt_pc(nxt_pc), .nxt_priv(nxt_priv), .resv_clr(resv_clr),
      .m_ie(m_ie), .m_pie(m_pie), .m_pp(m_pp), .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval),
      .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: mvec_m = d;
         3'd1: svec_m = d;
         3'd2: dexc_m = d;
         3'd3: dirq_m = d;
         default: ;
      endcase
   endtask

   task automatic do_trap(input bit a, input int c, input logic [1:0] p,
                          input logic [31:0] addr, input logic [31:0] pc);
      int          ec;
      bit          to_s;
      logic [31:0] tv, epc_exp, cause_exp, tval_exp, pc_exp;
      logic        pre_mie, pre_sie;
      logic [31:0] pre_mc, pre_sc;
      ec = c;
      if (!a && c == 8) ec = (p == 2'd0) ? 8 : (p == 2'd1) ? 9 : 11;
      to_s      = (p != 2'd3) && ((a ? dirq_m : dexc_m) >> ec) & 1;
      tv        = to_s ? svec_m : mvec_m;
      pc_exp    = {tv[31:2], 2'b00} + ((a && tv[1:0] == 2'b01) ? 32'(ec * 4) : 32'd0);
      cause_exp = (32'(a) << 31) | 32'(ec);
      tval_exp  = (!a && (ec <= 7 || ec == 12 || ec == 13 || ec == 15)) ? addr : 32'd0;
      epc_exp   = pc;
      pre_mie = m_ie; pre_sie = s_ie; pre_mc = m_cause; pre_sc = s_cause;
      @(negedge clk);
      trap_valid = 1'b1; trap_async = a; trap_code = 5'(c);
      trap_addr = addr; trap_pc = pc; cur_priv = p;
      #1;
      if (a && tv[1:0] == 2'b01) chk("R8 vectored pc", nxt_pc, pc_exp);
      else                       chk("R7 direct pc", nxt_pc, pc_exp);
      chk("R1 target level", 32'(nxt_priv), to_s ? 32'd1 : 32'd3);
      chk("R10 reservation clear", 32'(resv_clr), 32'd1);
      @(posedge clk);
      @(negedge clk);
      trap_valid = 1'b0;
      #1;
      if (!a && c == 8) chk("R9 call cause", to_s ? s_cause : m_cause, cause_exp);
      if (to_s) begin
         chk("R4 s cause", s_cause, cause_exp);
         chk("R5 s epc", s_epc, epc_exp);
         chk("R6 s tval", s_tval, tval_exp);
         chk("R2 s bits", {29'd0, s_ie, s_pie, s_pp}, {29'd0, 1'b0, pre_sie, p[0]});
         chk("R2 m untouched", m_cause, pre_mc);
         chk("R2 m ie kept", 32'(m_ie), 32'(pre_mie));
      end else begin
         chk("R4 m cause", m_cause, cause_exp);
         chk("R5 m epc", m_epc, epc_exp);
         chk("R6 m tval", m_tval, tval_exp);
         chk("R3 m bits", {28'd0, m_ie, m_pie, m_pp}, {28'd0, 1'b0, pre_mie, p});
         chk("R3 s untouched", s_cause, pre_sc);
         chk("R3 s ie kept", 32'(s_ie), 32'(pre_sie));
      end
      chk("R10 strobe drops", 32'(resv_clr), 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] keep_mc, keep_sc, keep_mt;
      logic [1:0]  privs [3];
      int          tick;
      privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
      mvec_m = '0; svec_m = '0; dexc_m = '0; dirq_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      chk("R11 m cause", m_cause, 0);
      chk("R11 s cause", s_cause, 0);
      chk("R11 epc/tval", m_epc | s_epc | m_tval | s_tval, 0);
      chk("R11 status bits", {26'd0, m_ie, m_pie, m_pp, s_ie, s_pie}, 0);
      chk("R11 s pp", 32'(s_pp), 0);
      chk("R11 vector zero", nxt_pc, 0);
      chk("R10 idle strobe", 32'(resv_clr), 0);

      tick = 0;
      for (int set = 0; set < 2; set++) begin
         if (set == 0) begin
            cfg(3'd0, 32'h8000_0101);
            cfg(3'd1, 32'h4000_0202);
            cfg(3'd2, 32'h0000_B3A5);
            cfg(3'd3, 32'h0000_0222);
         end else begin
            cfg(3'd0, 32'h8000_0400);
            cfg(3'd1, 32'h4000_1001);
            cfg(3'd2, 32'hFFFF_FFFF);
            cfg(3'd3, 32'hAAAA_5555);
         end
         for (int pi = 0; pi < 3; pi++) begin
            for (int a = 0; a < 2; a++) begin
               for (int c = 0; c < 32; c++) begin
                  cfg(3'd4, 32'((c + pi) & 3));
                  tick++;
                  do_trap(a[0], c, privs[pi], 32'hA000_0000 | 32'(c << 4) | 32'(pi),
                          32'h0010_0000 + 32'(tick * 4));
               end
            end
         end
      end

      // R12: write dropped when it collides with a trap
      cfg(3'd0, 32'h0000_0100);
      @(negedge clk);
      trap_valid = 1'b1; trap_async = 1'b0; trap_code = 5'd2; cur_priv = 2'd3;
      trap_pc = 32'h1234; trap_addr = 32'h55;
      cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 32'h0000_0900;
      @(negedge clk);
      trap_valid = 1'b0; cfg_we = 1'b0;
      #1;
      chk("R12 colliding write dropped", nxt_pc, 32'h0000_0100);
      do_trap(1'b0, 5, 2'd3, 32'h77, 32'h2000);

      // R13: idle cycles hold state
      keep_mc = m_cause; keep_sc = s_cause; keep_mt = m_tval;
      repeat (4) @(negedge clk);
      #1;
      chk("R13 m cause held", m_cause, keep_mc);
      chk("R13 s cause held", s_cause, keep_sc);
      chk("R13 m tval held", m_tval, keep_mt);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule